// File: doc/BRIEF.md
# Scanline Timing and Interrupt Generator

This block tracks the vertical position of a video raster. Elapsed time is accumulated in nanoseconds, a fixed amount per clock. Each time a full line period has passed, the line counter moves on one line. The amount left over past the period is kept for the next line, so fractional line lengths never drift. Two raster standards are available: 525 lines with a 31746 ns line, and 625 lines with a 32000 ns line. A single select input chooses between them.

At the end of each frame the counter returns to zero, emits a retrace pulse and marks a retrace as pending. Software programs two scanline compare values through one packed 32-bit write. The block then pulses a dedicated event whenever the raster arrives on either line. A pending retrace is resolved by a frame-latch strobe. That strobe fires when the raster reaches a fixed line after the wrap, or earlier when the display base address is rewritten. Every strobe advances a 32-bit frame counter.

Top module: `scanline_irq_gen`

## Requirements
- R1: With `STEP_NS` ns added per clock, a new line starts on the clock in which the accumulated time reaches the active line period. The remainder carries into the next line. `std_sel`=0 selects the 525-line standard (31746 ns lines) and `std_sel`=1 selects the 625-line standard (32000 ns lines), taking effect one clock after it is sampled.
- R2: On a new line, when the incremented count is at or above the active total (525 or 625), the count returns to 0, `retrace_o` pulses and a retrace becomes pending. This also catches a count that is already past a smaller total after a standard change.
- R3: A `cmp_we` write loads compare 1 from `cmp_wdata[25:16]` and compare 2 from `cmp_wdata[9:0]`. All other bits are ignored. The new values apply to lines that start after the write clock.
- R4: `scan1_o` / `scan2_o` pulse when the line just entered equals compare 1 / compare 2. Both may pulse together. A value at or above the active total never matches.
- R5: When the raster enters line 65 with a retrace pending, `frame_latch_o` pulses and the pending flag clears.
- R6: A `base_we` strobe while a retrace is pending pulses `frame_latch_o` on the next clock and clears the flag. Line 65 then gives no second strobe. A `base_we` strobe with nothing pending has no effect.
- R7: `frame_count_o` increases by one with every `frame_latch_o` pulse, modulo 2^32, and holds otherwise.
- R8: Synchronous reset selects the 525-line standard and clears the line count, the time remainder, both compare values, the pending flag, the frame counter and all event outputs.
- R9: All events are registered single-clock pulses. They appear on the clock after the one in which the line ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | Raster standard: 0 = 525 lines, 1 = 625 lines |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 32 | Packed compare values (bits 25:16 and 9:0) |
| base_we | input | 1 | Display base address write strobe |
| retrace_o | output | 1 | End-of-frame pulse |
| scan1_o | output | 1 | Compare 1 match pulse |
| scan2_o | output | 1 | Compare 2 match pulse |
| frame_latch_o | output | 1 | Frame latch strobe |
| frame_count_o | output | 32 | Count of frame latch strobes |

## Verification
The bench goes after the fractional line period. A design that dropped the remainder would give frame lengths that miss the alternating pair of cycle counts. It also goes after the early latch from a base-address write: a design that forgot to clear the pending flag would strobe a second time at line 65 and count two frames. Compare values beyond the active total must stay silent, and equal compare values must fire on the same clock. A switch from 625 to 525 lines partway down the raster must wrap at once; an equality-only wrap would keep counting up past 525. A per-clock reference model is also compared against all five outputs, which catches any off-by-one in event timing.

// File: rtl/scanline_pkg.sv
package scanline_pkg;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } std_e;

    typedef struct packed {
        logic retrace;
        logic scan1;
        logic scan2;
        logic latch;
    } evt_t;

    localparam int CMP_W      = 10;
    localparam int NUM_CMP    = 2;
    localparam int CMP_STRIDE = 16;
    localparam int FRAME_W    = 32;
    localparam logic [31:0] CMP_WORD_MASK = 32'h03FF_03FF;

    // compare 0 sits in the upper half-word, compare 1 in the lower
    function automatic int cmp_lsb(input int idx);
        return (NUM_CMP - 1 - idx) * CMP_STRIDE;
    endfunction

    function automatic logic [CMP_W-1:0] cmp_field(input logic [31:0] word, input int idx);
        logic [31:0] sh;
        sh = (word & CMP_WORD_MASK) >> cmp_lsb(idx);
        return sh[CMP_W-1:0];
    endfunction

endpackage

// File: rtl/scan_line_timer.sv
module scan_line_timer
    import scanline_pkg::*;
#(
    parameter int STEP_NS     = 20,
    parameter int LINE_NS_525 = 31746,
    parameter int LINE_NS_625 = 32000,
    parameter int REM_W       = 16
) (
    input  logic clk,
    input  logic rst,
    input  std_e mode,
    output logic line_tick
);

    localparam logic [REM_W-1:0] STEP_V = REM_W'(STEP_NS);
    localparam logic [REM_W-1:0] PER_A  = REM_W'(LINE_NS_525);
    localparam logic [REM_W-1:0] PER_B  = REM_W'(LINE_NS_625);

    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] sum;
    logic [REM_W-1:0] period;
    logic [REM_W-1:0] rem_d;

    always_comb begin
        sum       = rem_q + STEP_V;
        period    = (mode == STD_625) ? PER_B : PER_A;
        line_tick = (sum >= period);
        rem_d     = line_tick ? (sum - period) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

endmodule

// File: rtl/scan_line_counter.sv
module scan_line_counter
    import scanline_pkg::*;
#(
    parameter int TOTAL_525  = 525,
    parameter int TOTAL_625  = 625,
    parameter int LATCH_LINE = 65,
    parameter int LINE_W     = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  std_e               mode,
    input  logic               line_tick,
    input  logic               base_we,
    output logic [LINE_W-1:0]  line_next,
    output logic               retrace_q,
    output logic               latch_q,
    output logic               pending_q,
    output logic [FRAME_W-1:0] frame_q
);

    localparam logic [LINE_W-1:0] TOT_A   = LINE_W'(TOTAL_525);
    localparam logic [LINE_W-1:0] TOT_B   = LINE_W'(TOTAL_625);
    localparam logic [LINE_W-1:0] LATCH_V = LINE_W'(LATCH_LINE);
    localparam logic [LINE_W-1:0] ONE_V   = LINE_W'(1);

    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] inc;
    logic [LINE_W-1:0] total;
    logic              wrap;
    logic              at_latch;
    logic              base_fire;
    logic              latch_d;
    logic              pend_d;

    always_comb begin
        total     = (mode == STD_625) ? TOT_B : TOT_A;
        inc       = line_q + ONE_V;
        // at-or-above also recovers from a standard change mid-frame
        wrap      = (inc >= total);
        line_next = wrap ? '0 : inc;
        at_latch  = line_tick && (line_next == LATCH_V) && pending_q;
        base_fire = base_we && pending_q;
        latch_d   = at_latch || base_fire;
        pend_d    = (pending_q && !latch_d) || (line_tick && wrap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= '0;
            retrace_q <= 1'b0;
            latch_q   <= 1'b0;
            pending_q <= 1'b0;
            frame_q   <= '0;
        end else begin
            if (line_tick) begin
                line_q <= line_next;
            end
            retrace_q <= line_tick && wrap;
            latch_q   <= latch_d;
            pending_q <= pend_d;
            frame_q   <= frame_q + {{(FRAME_W-1){1'b0}}, latch_d};
        end
    end

endmodule

// File: rtl/scan_compare_bank.sv
module scan_compare_bank
    import scanline_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cmp_we,
    input  logic [31:0]                       cmp_wdata,
    input  logic                              line_tick,
    input  logic [LINE_W-1:0]                 line_next,
    output logic [NUM_CMP-1:0][CMP_W-1:0]     cmp_vals,
    output logic [NUM_CMP-1:0]                match_q
);

    localparam int CW = (LINE_W > CMP_W) ? LINE_W : CMP_W;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        logic [CMP_W-1:0] val_q;
        logic             hit;

        always_comb begin
            hit = line_tick && (CW'(line_next) == CW'(val_q));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q      <= '0;
                match_q[i] <= 1'b0;
            end else begin
                if (cmp_we) begin
                    val_q <= cmp_field(cmp_wdata, i);
                end
                match_q[i] <= hit;
            end
        end

        assign cmp_vals[i] = val_q;
    end

endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
    import scanline_pkg::*;
#(
    parameter int STEP_NS     = 20,
    parameter int LINE_NS_525 = 31746,
    parameter int LINE_NS_625 = 32000,
    parameter int TOTAL_525   = 525,
    parameter int TOTAL_625   = 625,
    parameter int LATCH_LINE  = 65
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        std_sel,
    input  logic        cmp_we,
    input  logic [31:0] cmp_wdata,
    input  logic        base_we,
    output logic        retrace_o,
    output logic        scan1_o,
    output logic        scan2_o,
    output logic        frame_latch_o,
    output logic [31:0] frame_count_o
);

    localparam int LINE_NS_MAX = (LINE_NS_625 > LINE_NS_525) ? LINE_NS_625 : LINE_NS_525;
    localparam int REM_W       = $clog2(LINE_NS_MAX + STEP_NS + 1);
    localparam int TOTAL_MAX   = (TOTAL_625 > TOTAL_525) ? TOTAL_625 : TOTAL_525;
    localparam int LINE_W      = $clog2(TOTAL_MAX + 1);

    std_e                          mode_q;
    logic                          line_tick;
    logic [LINE_W-1:0]             line_next;
    logic                          ret_q;
    logic                          lat_q;
    logic                          pending;
    logic [FRAME_W-1:0]            frames;
    logic [NUM_CMP-1:0][CMP_W-1:0] cmp_vals;
    logic [NUM_CMP-1:0]            match;
    evt_t                          evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= STD_525;
        end else begin
            mode_q <= std_e'(std_sel);
        end
    end

    scan_line_timer #(
        .STEP_NS     (STEP_NS),
        .LINE_NS_525 (LINE_NS_525),
        .LINE_NS_625 (LINE_NS_625),
        .REM_W       (REM_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .line_tick (line_tick)
    );

    scan_line_counter #(
        .TOTAL_525  (TOTAL_525),
        .TOTAL_625  (TOTAL_625),
        .LATCH_LINE (LATCH_LINE),
        .LINE_W     (LINE_W)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .line_tick (line_tick),
        .base_we   (base_we),
        .line_next (line_next),
        .retrace_q (ret_q),
        .latch_q   (lat_q),
        .pending_q (pending),
        .frame_q   (frames)
    );

    scan_compare_bank #(
        .LINE_W (LINE_W)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .line_tick (line_tick),
        .line_next (line_next),
        .cmp_vals  (cmp_vals),
        .match_q   (match)
    );

    always_comb begin
        evt.retrace = ret_q;
        evt.scan1   = match[0];
        evt.scan2   = match[1];
        evt.latch   = lat_q;
    end

    assign retrace_o     = evt.retrace;
    assign scan1_o       = evt.scan1;
    assign scan2_o       = evt.scan2;
    assign frame_latch_o = evt.latch;
    assign frame_count_o = frames;

endmodule

// File: rtl/scanline_irq_gen_chk.sv
module scanline_irq_gen_chk
    import scanline_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          line_tick,
    input logic                          cmp_we,
    input logic [31:0]                   cmp_wdata,
    input logic [NUM_CMP-1:0][CMP_W-1:0] cmp_vals,
    input logic                          pending,
    input logic                          retrace_o,
    input logic                          frame_latch_o,
    input logic [31:0]                   frame_count_o
);

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        line_tick |=> !line_tick);

    assert_retrace_pending_R2: assert property (@(posedge clk) disable iff (rst)
        retrace_o |-> pending);

    assert_cmp_load_R3: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> (cmp_vals[0] == $past(cmp_wdata[25:16])) && (cmp_vals[1] == $past(cmp_wdata[9:0])));

    assert_latch_clears_R5: assert property (@(posedge clk) disable iff (rst)
        frame_latch_o |-> !pending);

    assert_frame_step_R7: assert property (@(posedge clk) disable iff (rst)
        frame_latch_o |-> (frame_count_o == $past(frame_count_o) + 32'd1));

    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !frame_latch_o |-> $stable(frame_count_o));

    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |=> (!retrace_o && !frame_latch_o && !pending && frame_count_o == 32'd0));

    assert_single_retrace_R9: assert property (@(posedge clk) disable iff (rst)
        retrace_o |=> !retrace_o);

endmodule

bind scanline_irq_gen scanline_irq_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .line_tick     (line_tick),
    .cmp_we        (cmp_we),
    .cmp_wdata     (cmp_wdata),
    .cmp_vals      (cmp_vals),
    .pending       (pending),
    .retrace_o     (retrace_o),
    .frame_latch_o (frame_latch_o),
    .frame_count_o (frame_count_o)
);

// File: tb/scanline_irq_gen_tb.sv
module scanline_irq_gen_tb;

    localparam int STEP = 20;
    localparam int LA   = 70;
    localparam int LB   = 90;
    localparam int TA   = 525;
    localparam int TB   = 625;
    localparam int LL   = 65;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        std_sel = 1'b0;
    logic        cmp_we = 1'b0;
    logic [31:0] cmp_wdata = '0;
    logic        base_we = 1'b0;
    logic        retrace_o, scan1_o, scan2_o, frame_latch_o;
    logic [31:0] frame_count_o;

    always #10 clk = ~clk;

    scanline_irq_gen #(
        .STEP_NS     (STEP),
        .LINE_NS_525 (LA),
        .LINE_NS_625 (LB),
        .TOTAL_525   (TA),
        .TOTAL_625   (TB),
        .LATCH_LINE  (LL)
    ) u_dut (
        .clk           (clk),
        .rst           (rst),
        .std_sel       (std_sel),
        .cmp_we        (cmp_we),
        .cmp_wdata     (cmp_wdata),
        .base_we       (base_we),
        .retrace_o     (retrace_o),
        .scan1_o       (scan1_o),
        .scan2_o       (scan2_o),
        .frame_latch_o (frame_latch_o),
        .frame_count_o (frame_count_o)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    longint cyc   = 0;

    typedef struct packed {
        logic        r;
        logic        s1;
        logic        s2;
        logic        l;
        logic [31:0] fc;
    } exp_t;

    exp_t q[$];

    int        m_rem, m_line, m_c1, m_c2;
    bit        m_pend, m_mode;
    bit [31:0] m_frames;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // reference model: expected outputs visible after each rising edge
    always @(posedge clk) begin : model
        exp_t e;
        int   sum, per, tot, nl;
        bit   tick, wrap, lat;
        cyc++;
        e = '0;
        if (rst) begin
            m_rem = 0; m_line = 0; m_c1 = 0; m_c2 = 0;
            m_pend = 1'b0; m_mode = 1'b0; m_frames = '0;
        end else begin
            sum  = m_rem + STEP;
            per  = m_mode ? LB : LA;
            tick = (sum >= per);
            m_rem = tick ? sum - per : sum;
            wrap = 1'b0;
            nl   = m_line;
            if (tick) begin
                tot = m_mode ? TB : TA;
                nl  = m_line + 1;
                if (nl >= tot) begin
                    nl = 0;
                    wrap = 1'b1;
                end
                e.r  = wrap;
                e.s1 = (nl == m_c1);
                e.s2 = (nl == m_c2);
                m_line = nl;
            end
            lat = (tick && nl == LL && m_pend) || (base_we && m_pend);
            e.l = lat;
            m_pend = (m_pend && !lat) || (tick && wrap);
            if (lat) m_frames = m_frames + 32'd1;
            if (cmp_we) begin
                m_c1 = int'(cmp_wdata[25:16]);
                m_c2 = int'(cmp_wdata[9:0]);
            end
            m_mode = std_sel;
        end
        e.fc = m_frames;
        q.push_back(e);
    end

    // monitor: compares every clock away from the active edge
    always @(negedge clk) begin : monitor
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(retrace_o == e.r, "R2/R9 retrace_o", retrace_o, e.r);
            chk(scan1_o == e.s1, "R4 scan1_o", scan1_o, e.s1);
            chk(scan2_o == e.s2, "R4 scan2_o", scan2_o, e.s2);
            chk(frame_latch_o == e.l, "R5/R6 frame_latch_o", frame_latch_o, e.l);
            chk(frame_count_o == e.fc, "R7 frame_count_o", frame_count_o, e.fc);
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        finish_run();
    end

    task automatic wait_retrace(output longint t);
        do @(negedge clk); while (!retrace_o);
        t = cyc;
    endtask

    // counts events from one retrace to the next (closing retrace included)
    task automatic frame_counts(output int n1, output int n2, output int nl,
                                output longint gap, output longint lat_off);
        longint t0;
        n1 = 0; n2 = 0; nl = 0; lat_off = -1;
        wait_retrace(t0);
        do begin
            @(negedge clk);
            n1 += int'(scan1_o);
            n2 += int'(scan2_o);
            if (frame_latch_o) begin
                if (lat_off < 0) lat_off = cyc - t0;
                nl++;
            end
        end while (!retrace_o);
        gap = cyc - t0;
    endtask

    task automatic write_cmp(input logic [31:0] w);
        @(negedge clk);
        cmp_we = 1'b1; cmp_wdata = w;
        @(negedge clk);
        cmp_we = 1'b0; cmp_wdata = '0;
    endtask

    task automatic pulse_base();
        @(negedge clk);
        base_we = 1'b1;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    initial begin : stim
        int n1, n2, nl, k;
        longint gap, loff;
        logic [31:0] fc0;

        // R8: reset state
        repeat (4) @(negedge clk);
        chk(!retrace_o && !scan1_o && !scan2_o && !frame_latch_o, "R8 events in reset",
            {retrace_o, scan1_o, scan2_o, frame_latch_o}, 0);
        chk(frame_count_o == 0, "R8 frame count in reset", frame_count_o, 0);
        rst = 1'b0;

        // R1/R5/R4: first full 525 frame, compares at reset value 0
        frame_counts(n1, n2, nl, gap, loff);
        chk(gap == 1837 || gap == 1838, "R1 525-line frame length", gap, 1838);
        chk(nl == 1, "R5 one latch per frame", nl, 1);
        chk(loff == 227 || loff == 228, "R5 latch at line 65", loff, 228);
        chk(n1 == 1 && n2 == 1, "R8 compares cleared to line 0", n1 + n2, 2);

        // R3: packed fields with stray high bits
        write_cmp(32'hFC05_FC07);
        frame_counts(n1, n2, nl, gap, loff);
        chk(n1 == 1, "R3 compare 1 from bits 25:16", n1, 1);
        chk(n2 == 1, "R3 compare 2 from bits 9:0", n2, 1);

        // R4: equal compare values fire on the same clock
        write_cmp(32'h0014_0014);
        do @(negedge clk); while (!scan1_o);
        chk(scan2_o == 1'b1, "R4 both compares same line", scan2_o, 1);

        // R4: out-of-range compare values stay silent
        write_cmp(32'h03FF_0300);
        frame_counts(n1, n2, nl, gap, loff);
        chk(n1 == 0 && n2 == 0, "R4 compare beyond total", n1 + n2, 0);

        // R6: early latch from a base write while pending
        wait_retrace(gap);
        repeat (20) @(negedge clk);
        fc0 = frame_count_o;
        pulse_base();
        chk(frame_latch_o == 1'b1, "R6 base write latches", frame_latch_o, 1);
        chk(frame_count_o == fc0 + 32'd1, "R7 count after base latch", frame_count_o, fc0 + 32'd1);
        nl = 0;
        do begin
            @(negedge clk);
            nl += int'(frame_latch_o);
        end while (!retrace_o);
        chk(nl == 0, "R6 no second latch at line 65", nl, 0);

        // R6: base write with nothing pending is ignored
        do @(negedge clk); while (!frame_latch_o);
        repeat (5) @(negedge clk);
        fc0 = frame_count_o;
        pulse_base();
        chk(frame_latch_o == 1'b0, "R6 idle base write no latch", frame_latch_o, 0);
        chk(frame_count_o == fc0, "R6 idle base write no count", frame_count_o, fc0);

        // R1: 625-line standard
        std_sel = 1'b1;
        frame_counts(n1, n2, nl, gap, loff);
        frame_counts(n1, n2, nl, gap, loff);
        chk(gap == 2812 || gap == 2813, "R1 625-line frame length", gap, 2813);
        chk(nl == 1, "R5 latch in 625 frame", nl, 1);

        // R2: switching to 525 past line 525 wraps at once
        do @(negedge clk); while (m_line < 560);
        std_sel = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!retrace_o && k < 50);
        chk(k <= 8, "R2 wrap after standard change", k, 8);

        frame_counts(n1, n2, nl, gap, loff);
        chk(gap == 1837 || gap == 1838, "R1 525-line frame after switch", gap, 1838);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule